// File: doc/BRIEF.md
# Calendar Timekeeping Counter

This block keeps the time of day and the calendar date in binary-coded decimal. A prescaler divides a slow oscillator enable (nominally 32768 pulses per second) down to a one-second tick. Each tick advances a cascade of seven BCD fields: seconds, minutes, hours, day of month, weekday, month and two-digit year. The day field knows the length of every month. February has 29 days whenever the year value is a multiple of four, and that includes year 00.

A host reaches the fields through a byte-wide register port. A pointer load selects a start address. Each accepted read or write byte then moves the pointer on by one. After the last address the pointer returns to zero. While the host holds its transfer-active input high, the time fields stay frozen. A tick that arrives in that window is kept pending and is applied once the window closes, so a multi-byte read never shows fields from both sides of a carry. A stop bit in the control register freezes timekeeping and holds the prescaler at zero. A write to the seconds field also clears the prescaler, so a newly set second runs its full length.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day 01, weekday 00, month 01, year 00, and the control register reads 00. Addresses are: 0 control (bit 0 = stop), 1 seconds, 2 minutes, 3 hours, 4 day, 5 weekday, 6 month, 7 year.
- R2: Seconds and minutes roll from 59 to 00 and carry into the next field. Hours use the 24-hour format, rolling from 23 to 00 and carrying into day and weekday.
- R3: The day of month rolls over to 01 after 31 in January, March, May, July, August, October and December, after 30 in April, June, September and November, and after 28 in February of a non-leap year. Each of these rollovers carries into the month.
- R4: A year value whose two BCD digits form a multiple of four (00, 12, 24, ...) is a leap year, and February then runs to 29. Years such as 10 and 23 are not leap years.
- R5: The month rolls from 12 to 01 and carries into the year. The year rolls from 99 to 00.
- R6: The weekday counts 00 to 06 and wraps on its own. It advances on every day change, independent of the day of month.
- R7: `sec_tick_o` is a one-cycle pulse, raised once for every PRESC_DIV cycles in which `osc_tick_i` is high. Each such pulse advances the seconds by one when nothing holds the fields.
- R8: While stop = 1 the fields do not change and the prescaler is held at zero. After stop is cleared, the first advance needs a full PRESC_DIV oscillator pulses.
- R9: A write to the seconds field clears the prescaler and drops any pending tick.
- R10: The pointer increments after every accepted read or write byte. From ADDR_LAST (default 0x13) it wraps to 0x00. A pointer load takes priority over a data byte in the same cycle.
- R11: Addresses 8 to ADDR_LAST read 00, and writes to them have no effect. Unimplemented bits of a field read 0 (hours keep bits 5:0, for example).
- R12: While `xfer_active_i` or `wr_i` is high, no field advances. A tick that arrives in that time is applied once, after the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | One-cycle enable per oscillator period |
| xfer_active_i | input | 1 | Host transaction in progress; freezes the fields |
| ptr_load_i | input | 1 | Load the register pointer from ptr_i |
| ptr_i | input | AW | New pointer value |
| wr_i | input | 1 | Write wdata_i at the pointer, then increment |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read at the pointer, then increment |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| sec_tick_o | output | 1 | One-second tick pulse from the prescaler |

## Verification
The interesting collision is a one-second tick landing while the host is part way through a multi-byte read. The bench opens a transaction and reads the seconds at 59. It then drives a full prescaler period of oscillator pulses and reads the minutes and hours. It expects the pre-carry values 59 and 12, and only after the transaction closes does it expect 00:00:13. The same scheme covers a write racing a tick: the write holds the fields, and a seconds write drops the pending tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NF = 7;  // sec, min, hr, day, wday, mon, yr

  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DAY = 3;
  localparam int F_WD  = 4;
  localparam int F_MON = 5;
  localparam int F_YR  = 6;

  typedef logic [NF-1:0][7:0] fields_t;

  // index 6 down to 0
  localparam fields_t FIELD_MASK = {8'hFF, 8'h1F, 8'h07, 8'h3F, 8'h3F, 8'h7F, 8'h7F};
  localparam fields_t FIELD_RST  = {8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00};

  // BCD step; any value at or beyond hi returns lo
  function automatic logic [7:0] bcd_step(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
    if (v >= hi)            return lo;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10t+u) mod 4 == (2t+u) mod 4
  function automatic logic is_leap(logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(logic [7:0] mon, logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (osc_tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [7:0]    wdata_i,
  output fields_t       fields_o
);
  fields_t f_q, lo, hi, nxt;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;
  logic w_sec, w_min, w_hr, w_day, w_mon;
  logic [NF-1:0] inc;

  always_comb begin
    lo        = '0;
    lo[F_DAY] = 8'h01;
    lo[F_MON] = 8'h01;
    hi[F_SEC] = 8'h59;
    hi[F_MIN] = 8'h59;
    hi[F_HR]  = 8'h23;
    hi[F_DAY] = month_last(f_q[F_MON], is_leap(f_q[F_YR]));
    hi[F_WD]  = 8'h06;
    hi[F_MON] = 8'h12;
    hi[F_YR]  = 8'h99;
    for (int i = 0; i < NF; i++) nxt[i] = bcd_step(f_q[i], lo[i], hi[i]);
  end

  assign w_sec = f_q[F_SEC] >= hi[F_SEC];
  assign w_min = f_q[F_MIN] >= hi[F_MIN];
  assign w_hr  = f_q[F_HR]  >= hi[F_HR];
  assign w_day = f_q[F_DAY] >= hi[F_DAY];
  assign w_mon = f_q[F_MON] >= hi[F_MON];

  // weekday rides the day carry-in but does not feed the month
  assign c_sec = adv_i;
  assign c_min = c_sec & w_sec;
  assign c_hr  = c_min & w_min;
  assign c_day = c_hr & w_hr;
  assign c_mon = c_day & w_day;
  assign c_yr  = c_mon & w_mon;
  assign inc   = {c_yr, c_mon, c_day, c_day, c_hr, c_min, c_sec};

  for (genvar g = 0; g < NF; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          f_q[g] <= FIELD_RST[g];
      else if (we_i && sel_i == 3'(g))      f_q[g] <= wdata_i & FIELD_MASK[g];
      else if (inc[g])                      f_q[g] <= nxt[g];
    end
  end

  assign fields_o = f_q;
endmodule

// File: rtl/cal_regport.sv
module cal_regport
  import cal_pkg::*;
#(
  parameter int AW        = 8,
  parameter int ADDR_LAST = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          rd_i,
  input  fields_t       fields_i,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] ptr_o,
  output logic          stop_o,
  output logic          fld_we_o,
  output logic [2:0]    fld_sel_o,
  output logic          sec_wr_o
);
  localparam logic [AW-1:0] LAST = AW'(ADDR_LAST);

  logic [AW-1:0] ptr_q;
  logic          stop_q;
  logic          wr_ok, rd_ok, step;
  logic [7:0]    rd_val;
  logic          in_fields;

  assign wr_ok     = wr_i & ~ptr_load_i;
  assign rd_ok     = rd_i & ~ptr_load_i & ~wr_i;
  assign step      = wr_ok | rd_ok;
  assign in_fields = (ptr_q >= AW'(1)) && (ptr_q <= AW'(NF));

  always_comb begin
    rd_val = 8'h00;
    if (ptr_q == '0) rd_val = {7'b0, stop_q};
    for (int i = 0; i < NF; i++)
      if (ptr_q == AW'(i + 1)) rd_val = fields_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      stop_q  <= 1'b0;
      rdata_o <= 8'h00;
    end else begin
      if (rd_ok) rdata_o <= rd_val;
      if (wr_ok && ptr_q == '0) stop_q <= wdata_i[0];
      if (ptr_load_i)  ptr_q <= ptr_i;
      else if (step)   ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign fld_we_o  = wr_ok & in_fields;
  assign fld_sel_o = 3'(ptr_q - AW'(1));
  assign sec_wr_o  = wr_ok & (ptr_q == AW'(1));
  assign ptr_o     = ptr_q;
  assign stop_o    = stop_q;
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
#(
  parameter int PRESC_DIV = 32768,
  parameter int AW        = 8,
  parameter int ADDR_LAST = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          osc_tick_i,
  input  logic          xfer_active_i,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          rd_i,
  output logic [7:0]    rdata_o,
  output logic          sec_tick_o
);
  fields_t       fields;
  logic [AW-1:0] ptr_q;
  logic          stop_q, fld_we, sec_wr;
  logic [2:0]    fld_sel;
  logic          hold, pend_q, adv;

  assign hold = xfer_active_i | wr_i;
  assign adv  = (sec_tick_o | pend_q) & ~hold & ~stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (stop_q || sec_wr)   pend_q <= 1'b0;
    else                         pend_q <= (sec_tick_o | pend_q) & hold;
  end

  cal_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .osc_tick_i(osc_tick_i),
    .clr_i     (stop_q | sec_wr),
    .tick_o    (sec_tick_o)
  );

  cal_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .we_i    (fld_we),
    .sel_i   (fld_sel),
    .wdata_i (wdata_i),
    .fields_o(fields)
  );

  cal_regport #(.AW(AW), .ADDR_LAST(ADDR_LAST)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_load_i(ptr_load_i),
    .ptr_i     (ptr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rd_i      (rd_i),
    .fields_i  (fields),
    .rdata_o   (rdata_o),
    .ptr_o     (ptr_q),
    .stop_o    (stop_q),
    .fld_we_o  (fld_we),
    .fld_sel_o (fld_sel),
    .sec_wr_o  (sec_wr)
  );
endmodule

// File: rtl/cal_timekeeper_chk.sv
module cal_timekeeper_chk #(
  parameter int AW        = 8,
  parameter int ADDR_LAST = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sec_tick_i,
  input logic          xfer_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic          ptr_load_i,
  input logic [AW-1:0] ptr_i,
  input logic          stop_i,
  input logic          adv_i,
  input logic [7:0]    sec_i,
  input logic [7:0]    wd_i
);
  assert_tick_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_i |=> !sec_tick_i);

  assert_hold_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !wr_i) |=> $stable(sec_i) && $stable(wd_i));

  assert_stop_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_i) |=> $stable(sec_i) && $stable(wd_i));

  assert_sec_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> sec_i != $past(sec_i));

  assert_ptr_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !ptr_load_i && ptr_i >= AW'(ADDR_LAST)) |=> ptr_i == '0);

  assert_ptr_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !ptr_load_i && ptr_i < AW'(ADDR_LAST)) |=> ptr_i == $past(ptr_i) + 1'b1);
endmodule

bind cal_timekeeper cal_timekeeper_chk #(.AW(AW), .ADDR_LAST(ADDR_LAST)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sec_tick_i(sec_tick_o),
  .xfer_i    (xfer_active_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .ptr_load_i(ptr_load_i),
  .ptr_i     (ptr_q),
  .stop_i    (stop_q),
  .adv_i     (adv),
  .sec_i     (fields[0]),
  .wd_i      (fields[4])
);

// File: tb/cal_timekeeper_bench.sv
module cal_timekeeper_bench;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, osc = 1'b0, xfer = 1'b0;
  logic pl = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] ptr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic stk;

  int n_chk = 0, n_fail = 0, n_ticks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;
  logic [7:0] m_exp;
  string      m_tag;

  always #10 clk = ~clk;

  cal_timekeeper #(.PRESC_DIV(DIV)) u_cal_timekeeper (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc), .xfer_active_i(xfer),
    .ptr_load_i(pl), .ptr_i(ptr), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .sec_tick_o(stk)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk) rd_d <= rd && !pl && !wr;
  always @(negedge clk) begin
    if (stk) n_ticks++;
    if (rd_d) begin
      if (exp_q.size() == 0) check(0, "scoreboard empty", rdata, 0);
      else begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        check(rdata == m_exp, m_tag, rdata, m_exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    repeat (n) begin
      @(negedge clk) osc = 1'b1;
      @(negedge clk) osc = 1'b0;
    end
    idle(3);
  endtask

  task automatic set_ptr(logic [7:0] a);
    @(negedge clk) begin pl = 1'b1; ptr = a; end
    @(negedge clk) pl = 1'b0;
  endtask

  task automatic wr_byte(logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic rd_exp(logic [7:0] e, string tag);
    @(negedge clk) begin rd = 1'b1; exp_q.push_back(e); tag_q.push_back(tag); end
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic set_time(logic [7:0] s, mi, h, d, w, mo, y);
    xfer = 1'b1;
    set_ptr(8'h01);
    wr_byte(s); wr_byte(mi); wr_byte(h); wr_byte(d); wr_byte(w); wr_byte(mo); wr_byte(y);
    @(negedge clk) xfer = 1'b0;
  endtask

  task automatic read_time(logic [7:0] s, mi, h, d, w, mo, y, string tag);
    xfer = 1'b1;
    set_ptr(8'h01);
    rd_exp(s, {tag, " sec"});  rd_exp(mi, {tag, " min"}); rd_exp(h, {tag, " hr"});
    rd_exp(d, {tag, " day"});  rd_exp(w, {tag, " wday"}); rd_exp(mo, {tag, " mon"});
    rd_exp(y, {tag, " yr"});
    @(negedge clk) xfer = 1'b0;
    idle(2);
  endtask

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    read_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, "R1 reset");
    xfer = 1'b1; set_ptr(8'h00); rd_exp(8'h00, "R1 ctrl reset"); xfer = 1'b0; idle(2);

    // R2 R3 R6 R7: two seconds across midnight, Feb 28 of year 23
    set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h23);
    t0 = n_ticks;
    pulses(2 * DIV);
    check(n_ticks - t0 == 2, "R7 tick count", n_ticks - t0, 2);
    read_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h03, 8'h23, "R2 R3 R6 midnight");

    // R4 leap years
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h24);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h03, 8'h02, 8'h24, "R4 leap 24");
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h03, 8'h02, 8'h24);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h04, 8'h03, 8'h24, "R4 leap end");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h00);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h02, 8'h00, "R4 year 00");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h12);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h02, 8'h12, "R4 year 12");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h10);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h10, "R4 year 10");

    // R3 30- and 31-day months
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h04, 8'h21);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h05, 8'h21, "R3 april");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h01, 8'h21);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h31, 8'h06, 8'h01, 8'h21, "R3 january");

    // R5 R6 year rollover
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
    pulses(DIV);
    read_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, "R5 R6 new century");

    // R10 R11 pointer wrap and unimplemented space
    xfer = 1'b1;
    set_ptr(8'h13);
    rd_exp(8'h00, "R11 addr 13 reads 0");
    rd_exp(8'h00, "R10 wrap to ctrl");
    rd_exp(8'h00, "R10 then seconds");
    set_ptr(8'h08); wr_byte(8'hFF);
    set_ptr(8'h08); rd_exp(8'h00, "R11 addr 8 write ignored");
    set_ptr(8'h13); wr_byte(8'h5A); wr_byte(8'h01);  // second byte lands in ctrl
    set_ptr(8'h00); rd_exp(8'h01, "R10 write wrap to ctrl");
    set_ptr(8'h00); wr_byte(8'h00);
    set_ptr(8'h03); wr_byte(8'hE3);
    set_ptr(8'h03); rd_exp(8'h23, "R11 hour unimplemented bits");
    xfer = 1'b0; idle(2);

    // R8 stop freezes and resets prescaler
    set_time(8'h20, 8'h10, 8'h05, 8'h15, 8'h02, 8'h07, 8'h30);
    pulses(DIV - 1);
    xfer = 1'b1; set_ptr(8'h00); wr_byte(8'h01); xfer = 1'b0;
    t0 = n_ticks;
    pulses(3 * DIV);
    check(n_ticks == t0, "R8 no tick while stopped", n_ticks - t0, 0);
    read_time(8'h20, 8'h10, 8'h05, 8'h15, 8'h02, 8'h07, 8'h30, "R8 frozen");
    xfer = 1'b1; set_ptr(8'h00); wr_byte(8'h00); xfer = 1'b0;
    pulses(DIV - 1);
    read_time(8'h20, 8'h10, 8'h05, 8'h15, 8'h02, 8'h07, 8'h30, "R8 restart from zero");
    pulses(1);
    read_time(8'h21, 8'h10, 8'h05, 8'h15, 8'h02, 8'h07, 8'h30, "R8 first advance");

    // R9 seconds write clears prescaler
    pulses(DIV - 1);
    xfer = 1'b1; set_ptr(8'h01); wr_byte(8'h40); xfer = 1'b0;
    pulses(DIV - 1);
    read_time(8'h40, 8'h10, 8'h05, 8'h15, 8'h02, 8'h07, 8'h30, "R9 prescaler cleared");
    pulses(1);
    read_time(8'h41, 8'h10, 8'h05, 8'h15, 8'h02, 8'h07, 8'h30, "R9 full second");

    // R12 tick during a multi-byte read
    set_time(8'h59, 8'h59, 8'h12, 8'h05, 8'h01, 8'h06, 8'h30);
    xfer = 1'b1;
    set_ptr(8'h01);
    rd_exp(8'h59, "R12 sec before carry");
    t0 = n_ticks;
    pulses(DIV);
    check(n_ticks - t0 == 1, "R12 tick during read", n_ticks - t0, 1);
    rd_exp(8'h59, "R12 min held");
    rd_exp(8'h12, "R12 hr held");
    xfer = 1'b0;
    idle(3);
    read_time(8'h00, 8'h00, 8'h13, 8'h05, 8'h01, 8'h06, 8'h30, "R12 deferred tick applied");

    idle(3);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule